// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that counts on its own slow clock, separate from the register bus clock. A 12-bit down-counter is decremented once per prescaler period. When it runs out without being refreshed, the block drives a reset pulse of fixed width and then reloads itself. Software reaches the block through a small register port with four word addresses. Writing magic values to the key address unlocks the configuration, refreshes the counter or starts the watchdog.

The prescaler and reload settings live in the bus clock domain. Each one moves into the watchdog clock domain through a toggle handshake. While a transfer is in flight, a status bit for that register reads as one, and further writes to that register are dropped. Once started, by the start key or by a hardware strap, the watchdog cannot be stopped except by the block reset. A debug halt input can freeze the count when a freeze-enable pin allows it.

Top module: `wdt_top`

## Requirements
- R1: A key-address write of 0x5555 unlocks the prescaler and reload registers. A key write of any other value, including the refresh and start keys, locks them again. Writes to those registers while locked leave them unchanged.
- R2: The register map is as follows. Address 0 is the key register and reads as 0. Address 1 holds the prescaler code in bits [2:0]. Address 2 holds the reload value in bits [11:0]. Address 3 is status, with bit 0 showing a prescaler transfer pending and bit 1 showing a reload transfer pending. After reset, the prescaler reads 0, the reload reads 0xFFF, status reads 0 and the reset output is low.
- R3: Once running, the reset output rises every (reload + 1) × divisor watchdog clock periods. After each pulse the counter restarts from the reload value.
- R4: Prescaler codes 0 to 6 divide by 4, 8, 16, 32, 64, 128 and 256. Code 7 also divides by 256.
- R5: A key write of 0xAAAA reloads the counter. Refreshing more often than the timeout keeps the reset output low. The first pulse follows the last refresh after the timeout plus a crossing delay of one to six watchdog periods.
- R6: After reset with the strap low, the counter does not run. A refresh alone does not start it. A key write of 0xCCCC starts it, and later key writes cannot stop it.
- R7: With the hardware-start strap high, the watchdog runs with no start key written.
- R8: An accepted prescaler or reload write sets its status bit. The bit clears once the watchdog domain has taken the value. A write to that register while its bit is set is ignored.
- R9: While the debug halt input and the freeze-enable input are both high, the counter holds. With freeze-enable low, the halt input has no effect on the count.
- R10: Each reset pulse lasts exactly PULSE_CYCLES watchdog clock periods (4 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Register bus clock |
| wdClk | input | 1 | Watchdog counting clock |
| rstN | input | 1 | Active-low asynchronous reset, both domains |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for regAddr |
| hwStart | input | 1 | Strap: run from reset without a start key |
| dbgHalt | input | 1 | System halted for debug |
| dbgFreezeEn | input | 1 | Allow debug halt to freeze the counter |
| wdReset | output | 1 | Watchdog reset pulse, watchdog clock domain |

## Verification
A corrupted count, a wrong divisor decode or a lost refresh appears at wdReset as a pulse spacing that differs from (reload + 1) × divisor. This shows up within one timeout period. A broken handshake shows as a status bit that never clears, or as a readback that changed when it should have been blocked, within a few watchdog clocks of the write. A broken lock is visible on the next read of the register. A faulty freeze gate produces a pulse during a halt window far longer than the timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int KEY_W      = 16;
  localparam int RLD_W      = 12;
  localparam int PRE_W      = 3;
  localparam int ADDR_W     = 2;
  localparam int BASE_SHIFT = 2;   // smallest divisor is 1 << BASE_SHIFT
  localparam int MAX_SHIFT  = 6;   // codes above this saturate

  localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;

  localparam logic [ADDR_W-1:0] ADDR_KEY  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRE  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_RLD  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;

  // Bus-side control towards the watchdog domain
  typedef struct packed {
    logic [PRE_W-1:0] preVal;
    logic [RLD_W-1:0] rldVal;
    logic             preTgl;
    logic             rldTgl;
    logic             refreshTgl;
    logic             startReq;
  } xfer_t;

  // Watchdog-side acknowledge toggles back to the bus
  typedef struct packed {
    logic preAck;
    logic rldAck;
  } ack_t;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[0] <= '0;
        else       stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[i] <= '0;
        else       stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [KEY_W-1:0]  regWrData,
  output logic [KEY_W-1:0]  regRdData,
  output xfer_t             xfer,
  input  ack_t              ack
);
  logic             unlocked;
  logic [PRE_W-1:0] preReg;
  logic [RLD_W-1:0] rldReg;
  logic             preTgl, rldTgl, refreshTgl, startReq;
  logic [1:0]       ackSync;
  logic             prePend, rldPend;
  logic             keyWr, preWr, rldWr;

  wdt_sync #(.STAGES(SYNC_STAGES), .W(2)) u_ackSync (
    .clk (busClk),
    .rstN(rstN),
    .d   ({ack.preAck, ack.rldAck}),
    .q   (ackSync)
  );

  assign prePend = preTgl ^ ackSync[1];
  assign rldPend = rldTgl ^ ackSync[0];

  always_comb begin
    keyWr = regWrEn && (regAddr == ADDR_KEY);
    preWr = regWrEn && (regAddr == ADDR_PRE) && unlocked && !prePend;
    rldWr = regWrEn && (regAddr == ADDR_RLD) && unlocked && !rldPend;
  end

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      unlocked   <= 1'b0;
      preReg     <= '0;
      rldReg     <= '1;
      preTgl     <= 1'b0;
      rldTgl     <= 1'b0;
      refreshTgl <= 1'b0;
      startReq   <= 1'b0;
    end else begin
      if (keyWr) begin
        unlocked <= (regWrData == KEY_UNLOCK);
        if (regWrData == KEY_REFRESH) refreshTgl <= ~refreshTgl;
        if (regWrData == KEY_START)   startReq   <= 1'b1;
      end
      if (preWr) begin
        preReg <= regWrData[PRE_W-1:0];
        preTgl <= ~preTgl;
      end
      if (rldWr) begin
        rldReg <= regWrData[RLD_W-1:0];
        rldTgl <= ~rldTgl;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_PRE:  regRdData[PRE_W-1:0] = preReg;
      ADDR_RLD:  regRdData[RLD_W-1:0] = rldReg;
      ADDR_STAT: regRdData[1:0]       = {rldPend, prePend};
      default:   regRdData            = '0;
    endcase
  end

  always_comb begin
    xfer.preVal     = preReg;
    xfer.rldVal     = rldReg;
    xfer.preTgl     = preTgl;
    xfer.rldTgl     = rldTgl;
    xfer.refreshTgl = refreshTgl;
    xfer.startReq   = startReq;
  end
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int PULSE_CYCLES = 4
) (
  input  logic  wdClk,
  input  logic  rstN,
  input  xfer_t xfer,
  input  logic  hwStart,
  input  logic  dbgHalt,
  input  logic  dbgFreezeEn,
  output ack_t  ack,
  output logic  wdReset
);
  localparam int DIV_W = BASE_SHIFT + MAX_SHIFT;
  localparam int PW    = $clog2(PULSE_CYCLES + 1);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] syncIn, syncOut, syncLast;
  logic             preEv, rldEv, refreshEv, startEv, frozen, loadNow;
  logic [PRE_W-1:0] preEff, shiftSel;
  logic [RLD_W-1:0] rldEff, cnt;
  logic [DIV_W-1:0] preCnt;
  logic [DIV_W:0]   divLast;
  logic             running, tick, fireNow;
  logic [PW-1:0]    pulseCnt;

  assign syncIn = {xfer.preTgl, xfer.rldTgl, xfer.refreshTgl, xfer.startReq,
                   dbgHalt & dbgFreezeEn};

  wdt_sync #(.STAGES(SYNC_STAGES), .W(NSYNC)) u_cfgSync (
    .clk (wdClk),
    .rstN(rstN),
    .d   (syncIn),
    .q   (syncOut)
  );

  always_ff @(posedge wdClk or negedge rstN) begin
    if (!rstN) syncLast <= '0;
    else       syncLast <= syncOut;
  end

  always_comb begin
    preEv     = syncOut[4] ^ syncLast[4];
    rldEv     = syncOut[3] ^ syncLast[3];
    refreshEv = syncOut[2] ^ syncLast[2];
    startEv   = syncOut[1] & ~syncLast[1];
    frozen    = syncOut[0];
    loadNow   = refreshEv | startEv;
  end

  // divisor select, saturating above MAX_SHIFT
  always_comb begin
    shiftSel = (preEff > PRE_W'(MAX_SHIFT)) ? PRE_W'(MAX_SHIFT) : preEff;
    divLast  = ((DIV_W+1)'(1) << (BASE_SHIFT + int'(shiftSel))) - (DIV_W+1)'(1);
    tick     = ({1'b0, preCnt} >= divLast);
    fireNow  = !loadNow && running && !frozen && tick && (cnt == '0);
  end

  always_ff @(posedge wdClk or negedge rstN) begin
    if (!rstN) begin
      preEff   <= '0;
      rldEff   <= '1;
      cnt      <= '1;
      preCnt   <= '0;
      running  <= 1'b0;
      pulseCnt <= '0;
    end else begin
      if (preEv) preEff <= xfer.preVal;
      if (rldEv) rldEff <= xfer.rldVal;
      running <= running | hwStart | startEv;

      if (fireNow)              pulseCnt <= PW'(PULSE_CYCLES);
      else if (pulseCnt != '0)  pulseCnt <= pulseCnt - 1'b1;

      if (loadNow) begin
        cnt    <= rldEff;
        preCnt <= '0;
      end else if (running && !frozen) begin
        if (tick) begin
          preCnt <= '0;
          cnt    <= (cnt == '0) ? rldEff : cnt - 1'b1;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end

  assign wdReset    = (pulseCnt != '0);
  assign ack.preAck = syncLast[4];
  assign ack.rldAck = syncLast[3];
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int PULSE_CYCLES = 4
) (
  input  logic              busClk,
  input  logic              wdClk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [KEY_W-1:0]  regWrData,
  output logic [KEY_W-1:0]  regRdData,
  input  logic              hwStart,
  input  logic              dbgHalt,
  input  logic              dbgFreezeEn,
  output logic              wdReset
);
  xfer_t xfer;
  ack_t  ack;

  wdt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .busClk   (busClk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .xfer     (xfer),
    .ack      (ack)
  );

  wdt_datapath #(.SYNC_STAGES(SYNC_STAGES), .PULSE_CYCLES(PULSE_CYCLES)) u_dp (
    .wdClk      (wdClk),
    .rstN       (rstN),
    .xfer       (xfer),
    .hwStart    (hwStart),
    .dbgHalt    (dbgHalt),
    .dbgFreezeEn(dbgFreezeEn),
    .ack        (ack),
    .wdReset    (wdReset)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input logic              busClk,
  input logic              wdClk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [KEY_W-1:0]  regWrData,
  input xfer_t             xfer,
  input logic              wdReset
);
  logic [31:0] hiLen;

  always_ff @(posedge wdClk or negedge rstN) begin
    if (!rstN)        hiLen <= '0;
    else if (wdReset) hiLen <= hiLen + 1;
    else              hiLen <= '0;
  end

  // R1: a relocking key followed by a prescaler write leaves the value alone
  p_relock_blocks_r1: assert property (@(posedge busClk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_KEY && regWrData != KEY_UNLOCK) ##1
    (regWrEn && regAddr == ADDR_PRE) |=> $stable(xfer.preVal));

  // R1: configuration value moves only together with its transfer toggle
  p_value_with_toggle_r1: assert property (@(posedge busClk) disable iff (!rstN)
    !$stable(xfer.rldVal) |-> !$stable(xfer.rldTgl));

  // R8: a write right after an accepted one is dropped while pending
  p_pending_blocks_r8: assert property (@(posedge busClk) disable iff (!rstN)
    (xfer.preTgl != $past(xfer.preTgl)) && regWrEn && regAddr == ADDR_PRE
    |=> $stable(xfer.preVal));

  // R8: transfers are launched only by writes to their own address
  p_toggle_source_r8: assert property (@(posedge busClk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_RLD) |=> $stable(xfer.rldTgl));

  // R5: the refresh key always launches a refresh
  p_refresh_launch_r5: assert property (@(posedge busClk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_KEY && regWrData == KEY_REFRESH)
    |=> (xfer.refreshTgl != $past(xfer.refreshTgl)));

  // R6: once started, the start request never drops
  p_start_sticky_r6: assert property (@(posedge busClk) disable iff (!rstN)
    xfer.startReq |=> xfer.startReq);

  // R10: every pulse has the fixed width
  p_pulse_width_r10: assert property (@(posedge wdClk) disable iff (!rstN)
    $fell(wdReset) |-> (hiLen == 32'(PULSE_CYCLES)));
endmodule

bind wdt_top wdt_checker #(.PULSE_CYCLES(PULSE_CYCLES)) u_wdtChk (
  .busClk   (busClk),
  .wdClk    (wdClk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .xfer     (xfer),
  .wdReset  (wdReset)
);

// File: tb/wdt_top_bench.sv
module wdt_top_bench;
  logic        busClk = 1'b0;
  logic        wdClk  = 1'b0;
  logic        rstN   = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = 16'd0;
  logic [15:0] regRdData;
  logic        hwStart = 1'b0;
  logic        dbgHalt = 1'b0;
  logic        dbgFreezeEn = 1'b0;
  logic        wdReset;

  int checkCount = 0;
  int failCount  = 0;
  int wdEdges    = 0;
  int pulseCount = 0;
  int lastRise   = 0;
  int lastWidth  = 0;
  int curWidth   = 0;
  logic prevRst  = 1'b0;
  bit   done     = 1'b0;

  always #4  busClk = ~busClk;   // 125 MHz
  always #22 wdClk  = ~wdClk;

  wdt_top u_wdt_top (
    .busClk(busClk), .wdClk(wdClk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .hwStart(hwStart), .dbgHalt(dbgHalt),
    .dbgFreezeEn(dbgFreezeEn), .wdReset(wdReset)
  );

  always @(posedge wdClk) wdEdges++;

  always @(negedge wdClk) begin
    if (wdReset && !prevRst) begin
      pulseCount++;
      lastRise = wdEdges;
      curWidth = 1;
    end else if (wdReset) begin
      curWidth++;
    end else if (prevRst) begin
      lastWidth = curWidth;
    end
    prevRst = wdReset;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge busClk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge busClk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output int d);
    @(negedge busClk);
    regAddr = a;
    #1 d = int'(regRdData);
  endtask

  task automatic waitWd(input int n);
    repeat (n) @(negedge wdClk);
  endtask

  task automatic waitPulse(input int limit, output int rise, output bit ok);
    int base;
    base = pulseCount;
    ok = 1'b0;
    rise = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge wdClk);
      #1;
      if (pulseCount != base) begin
        ok = 1'b1;
        rise = lastRise;
        break;
      end
    end
  endtask

  function automatic int expT(input int pre, input int rld);
    int sh;
    sh = (pre > 6) ? 6 : pre;
    return (rld + 1) * (4 << sh);
  endfunction

  task automatic waitIdle();
    int st;
    for (int i = 0; i < 200; i++) begin
      busRead(2'd3, st);
      if (st == 0) break;
    end
  endtask

  task automatic configure(input int pre, input int rld);
    waitIdle();
    busWrite(2'd0, 16'h5555);
    busWrite(2'd1, 16'(pre));
    busWrite(2'd2, 16'(rld));
    busWrite(2'd0, 16'h0000);
    waitIdle();
  endtask

  task automatic applyReset(input logic strap);
    rstN = 1'b0;
    hwStart = strap;
    dbgHalt = 1'b0;
    dbgFreezeEn = 1'b0;
    repeat (5) @(negedge busClk);
    waitWd(2);
    rstN = 1'b1;
    waitWd(2);
  endtask

  task automatic t_reset();
    int v;
    busRead(2'd1, v); check(v == 0, "R2 reset prescaler", v, 0);
    busRead(2'd2, v); check(v == 12'hFFF, "R2 reset reload", v, 12'hFFF);
    busRead(2'd3, v); check(v == 0, "R2 reset status", v, 0);
    busRead(2'd0, v); check(v == 0, "R2 key reads zero", v, 0);
    check(wdReset == 1'b0, "R2 reset output low", int'(wdReset), 0);
  endtask

  task automatic t_lock();
    int v;
    busWrite(2'd1, 16'd3);
    busRead(2'd1, v); check(v == 0, "R1 locked write ignored", v, 0);
    busWrite(2'd0, 16'h5555); busWrite(2'd0, 16'h1234); busWrite(2'd1, 16'd3);
    busRead(2'd1, v); check(v == 0, "R1 other key relocks", v, 0);
    busWrite(2'd0, 16'h5555); busWrite(2'd0, 16'hAAAA); busWrite(2'd2, 16'h123);
    busRead(2'd2, v); check(v == 12'hFFF, "R1 refresh key relocks", v, 12'hFFF);
    busWrite(2'd0, 16'h5555); busWrite(2'd1, 16'd3);
    busRead(2'd1, v); check(v == 3, "R1 unlocked write accepted", v, 3);
    waitIdle();
    busWrite(2'd0, 16'h0000);
  endtask

  task automatic t_pending();
    int v;
    busWrite(2'd0, 16'h5555);
    busWrite(2'd2, 16'h010);
    busRead(2'd3, v); check(v == 2, "R8 reload pending set", v, 2);
    busWrite(2'd2, 16'h020);
    busRead(2'd2, v); check(v == 16'h010, "R8 write while pending ignored", v, 16'h010);
    waitWd(20);
    busRead(2'd3, v); check(v == 0, "R8 reload pending clears", v, 0);
    busWrite(2'd1, 16'd2);
    busRead(2'd3, v); check(v == 1, "R8 prescaler pending set", v, 1);
    waitWd(20);
    busRead(2'd3, v); check(v == 0, "R8 prescaler pending clears", v, 0);
    busRead(2'd1, v); check(v == 2, "R2 prescaler readback", v, 2);
    busWrite(2'd0, 16'h0000);
  endtask

  task automatic t_start();
    int t, st, rise, base;
    bit ok;
    configure(0, 3);
    t = expT(0, 3);
    base = pulseCount;
    busWrite(2'd0, 16'hAAAA);
    waitWd(200);
    check(pulseCount == base, "R6 idle before start key", pulseCount - base, 0);
    @(negedge busClk);
    st = wdEdges;
    busWrite(2'd0, 16'hCCCC);
    waitPulse(t + 40, rise, ok);
    check(ok && (rise - st) >= t + 1 && (rise - st) <= t + 6,
          "R6 start key runs counter", rise - st, t + 3);
  endtask

  task automatic t_period(input int pre, input int rld, input string tag);
    int t, a, b;
    bit ok1, ok2;
    configure(pre, rld);
    t = expT(pre, rld);
    waitPulse(100000, a, ok1);
    waitPulse(t + 20, b, ok2);
    check(ok1 && ok2 && (b - a) == t, tag, b - a, t);
    waitWd(1);
    check(lastWidth == 4, "R10 pulse width", lastWidth, 4);
  endtask

  task automatic t_refresh();
    int t, base, st, rise;
    bit ok;
    configure(0, 15);
    t = expT(0, 15);
    busWrite(2'd0, 16'hAAAA);
    waitWd(8);
    base = pulseCount;
    for (int i = 0; i < 10; i++) begin
      busWrite(2'd0, 16'hAAAA);
      waitWd(30);
    end
    check(pulseCount == base, "R5 refresh keeps reset low", pulseCount - base, 0);
    @(negedge busClk);
    st = wdEdges;
    busWrite(2'd0, 16'hAAAA);
    waitPulse(t + 40, rise, ok);
    check(ok && (rise - st) >= t + 1 && (rise - st) <= t + 6,
          "R5 timeout after last refresh", rise - st, t + 3);
  endtask

  task automatic t_freeze();
    int t, base, st, a, b;
    bit ok1, ok2;
    t = expT(0, 15);
    dbgFreezeEn = 1'b1;
    dbgHalt = 1'b1;
    waitWd(4);
    busWrite(2'd0, 16'hAAAA);
    waitWd(8);
    base = pulseCount;
    waitWd(300);
    check(pulseCount == base, "R9 frozen counter holds", pulseCount - base, 0);
    @(negedge busClk);
    st = wdEdges;
    dbgHalt = 1'b0;
    waitPulse(t + 40, a, ok1);
    check(ok1 && (a - st) >= t + 1 && (a - st) <= t + 6,
          "R9 count resumes after halt", a - st, t + 3);
    dbgFreezeEn = 1'b0;
    dbgHalt = 1'b1;
    waitPulse(t + 20, a, ok1);
    waitPulse(t + 20, b, ok2);
    check(ok1 && ok2 && (b - a) == t, "R9 halt ignored without freeze enable", b - a, t);
    dbgHalt = 1'b0;
  endtask

  task automatic t_noStop();
    int t, a, b;
    bit ok1, ok2;
    t = expT(0, 15);
    busWrite(2'd0, 16'h0000);
    busWrite(2'd0, 16'h5555);
    busWrite(2'd0, 16'h1111);
    waitPulse(t + 20, a, ok1);
    waitPulse(t + 20, b, ok2);
    check(ok1 && ok2 && (b - a) == t, "R6 key writes cannot stop", b - a, t);
  endtask

  task automatic t_hwStart();
    int t, st, rise;
    bit ok;
    applyReset(1'b1);
    configure(0, 7);
    t = expT(0, 7);
    @(negedge busClk);
    st = wdEdges;
    busWrite(2'd0, 16'hAAAA);
    waitPulse(t + 40, rise, ok);
    check(ok && (rise - st) >= t + 1 && (rise - st) <= t + 6,
          "R7 strap runs without start key", rise - st, t + 3);
  endtask

  initial begin
    applyReset(1'b0);
    t_reset();
    t_lock();
    t_pending();
    t_start();
    t_period(0, 3,  "R3 period code0 reload3");
    t_period(1, 0,  "R4 divide by 8 reload0");
    t_period(2, 9,  "R4 divide by 16");
    t_period(3, 5,  "R4 divide by 32");
    t_period(6, 2,  "R4 divide by 256 code6");
    t_period(7, 2,  "R4 code7 divides by 256");
    t_refresh();
    t_freeze();
    t_noStop();
    t_hwStart();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge busClk);
    if (!done) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end
endmodule